// File: doc/BRIEF.md
# Thermal Threshold Interrupt Monitor

This block watches the stream of filtered temperature codes from one sensor channel and turns threshold crossings into sticky interrupt status bits. A filter upstream presents a 12-bit unsigned code together with a one-cycle valid strobe. On each strobe, and only while monitoring is switched on, the code is tested against five programmable thresholds: a pair of offset limits forming a window, a cold limit, and a hot test that uses the larger of the hot limit and a normal-to-hot limit.

Software programs the thresholds, the monitor switch and a 32-bit interrupt enable mask through a simple word-addressed register port. It reads a 32-bit status word and clears bits by writing ones to them. A single registered level interrupt is raised while any status bit is set whose enable bit is also set. Until the normal-to-hot limit has been written once after reset, the cold limit stands in for it in the hot test.

Top module: `thermal_irq_monitor`

## Requirements
- R1: Register word addresses are 0 control, 1 hot limit, 2 normal-to-hot limit, 3 cold limit, 4 low-offset limit, 5 high-offset limit, 6 interrupt enable, 7 status. Each limit stores bits 11:0 of the written word; bits 31:12 read back as zero. Read data appears on `reg_rdata` one clock after `reg_addr` is presented.
- R2: A sample strictly greater than the high-offset limit sets status bit 2.
- R3: A sample strictly less than the low-offset limit sets status bit 3.
- R4: A sample strictly less than the cold limit sets status bit 1.
- R5: A sample strictly greater than the larger of the hot and normal-to-hot limits sets both status bit 0 and status bit 4.
- R6: While the normal-to-hot limit has not been written since reset, the cold limit replaces it in the hot test of R5.
- R7: Status bits are sticky; writing to address 7 clears exactly the bits that are 1 in the written word.
- R8: When a clear write and a set from a sample hit the same bit on the same cycle, the bit ends up set.
- R9: `irq` is high one clock after the status and enable registers hold a bit that is set in both, and low one clock after no such bit exists; enable bit k gates status bit k.
- R10: Samples are compared only on cycles with `smp_valid` high and control bit 0 set; otherwise status is unchanged.
- R11: After reset every register reads zero and `irq` is low.
- R12: Status bits 31:5 never become set, including by writes to the status address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| smp_valid | input | 1 | Filtered sample strobe |
| smp_code | input | 12 | Unsigned temperature code |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a status clear write landing on exactly the same clock edge as a sample that sets the same bit; the stimulus gets there with a dedicated task that raises the write strobe and the sample strobe in the same cycle. The cold-limit fallback of the hot test is only visible before the normal-to-hot limit is ever written, so that case is run early, with the hot limit below the cold limit so that the fallback changes the outcome. Each compare rule is probed at its limit and one code beyond it to pin down strictness.

// File: rtl/thmon_pkg.sv
package thmon_pkg;
  // limit slots in the threshold bank
  localparam int THR_HOT   = 0;
  localparam int THR_N2H   = 1;
  localparam int THR_COLD  = 2;
  localparam int THR_LOFS  = 3;
  localparam int THR_HOFS  = 4;
  localparam int NUM_THR   = 5;

  // word address map
  localparam int ADR_CTRL  = 0;
  localparam int ADR_THR0  = 1;
  localparam int ADR_INTEN = 6;
  localparam int ADR_STAT  = 7;

  // status bit positions
  localparam int ST_HOT    = 0;
  localparam int ST_COLD   = 1;
  localparam int ST_HOFS   = 2;
  localparam int ST_LOFS   = 3;
  localparam int ST_N2H    = 4;
  localparam int ST_USED   = 5;
endpackage

// File: rtl/thmon_regs.sv
module thmon_regs
  import thmon_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic                            mon_en,
  output logic [NUM_THR-1:0][TEMP_W-1:0]  thr,
  output logic                            n2h_set,
  output logic [DATA_W-1:0]               int_en,
  output logic                            clr_we,
  output logic [DATA_W-1:0]               clr_vec
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_INTEN = ADDR_W'(ADR_INTEN);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_N2H   = ADDR_W'(ADR_THR0 + THR_N2H);

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_en <= 1'b0;
    end else if (we && addr == A_CTRL) begin
      mon_en <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en <= '0;
    end else if (we && addr == A_INTEN) begin
      int_en <= wdata;
    end
  end

  // one slot per limit, each with its own address decode
  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(ADR_THR0 + g);
    always_ff @(posedge clk) begin
      if (rst) begin
        thr[g] <= '0;
      end else if (we && addr == A_SLOT) begin
        thr[g] <= wdata[TEMP_W-1:0];
      end
    end
  end

  // remembers whether the normal-to-hot limit was ever programmed
  always_ff @(posedge clk) begin
    if (rst) begin
      n2h_set <= 1'b0;
    end else if (we && addr == A_N2H) begin
      n2h_set <= 1'b1;
    end
  end

  always_comb begin
    clr_we  = we && (addr == A_STAT);
    clr_vec = wdata;
  end
endmodule

// File: rtl/thmon_compare.sv
module thmon_compare
  import thmon_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                            smp_valid,
  input  logic [TEMP_W-1:0]               smp_code,
  input  logic                            mon_en,
  input  logic [NUM_THR-1:0][TEMP_W-1:0]  thr,
  input  logic                            n2h_set,
  output logic [DATA_W-1:0]               set_vec
);
  logic [TEMP_W-1:0] hot_ref;
  logic [TEMP_W-1:0] hot_lim;
  logic              go;
  logic              above_hot;
  logic              above_hofs;
  logic              below_lofs;
  logic              below_cold;

  always_comb begin
    // unprogrammed normal-to-hot limit falls back to the cold limit
    hot_ref    = n2h_set ? thr[THR_N2H] : thr[THR_COLD];
    hot_lim    = (thr[THR_HOT] > hot_ref) ? thr[THR_HOT] : hot_ref;
    go         = smp_valid && mon_en;
    above_hot  = smp_code > hot_lim;
    above_hofs = smp_code > thr[THR_HOFS];
    below_lofs = smp_code < thr[THR_LOFS];
    below_cold = smp_code < thr[THR_COLD];
  end

  always_comb begin
    set_vec = '0;
    if (go) begin
      set_vec[ST_HOT]  = above_hot;
      set_vec[ST_N2H]  = above_hot;
      set_vec[ST_HOFS] = above_hofs;
      set_vec[ST_LOFS] = below_lofs;
      set_vec[ST_COLD] = below_cold;
    end
  end
endmodule

// File: rtl/thmon_status.sv
module thmon_status
  import thmon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] set_vec,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_vec,
  input  logic [DATA_W-1:0] int_en,
  output logic [DATA_W-1:0] status,
  output logic              irq
);
  localparam logic [DATA_W-1:0] USED_MASK = DATA_W'((64'd1 << ST_USED) - 64'd1);

  logic [DATA_W-1:0] clr_eff;
  logic [DATA_W-1:0] status_nxt;

  always_comb begin
    clr_eff    = clr_we ? clr_vec : '0;
    // set is applied after clear so a same-cycle set survives
    status_nxt = ((status & ~clr_eff) | set_vec) & USED_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nxt;
      irq    <= |(status & int_en);
    end
  end

  // R7: without a clear write, no set bit may drop
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((status & $past(status)) == $past(status)));

  // R8: a set coinciding with a clear write wins
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_we && (|set_vec)) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R12: upper status bits stay clear
  p_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
    status[DATA_W-1:ST_USED] == '0);
endmodule

// File: rtl/thermal_irq_monitor.sv
module thermal_irq_monitor
  import thmon_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              smp_valid,
  input  logic [TEMP_W-1:0] smp_code,
  output logic              irq
);
  logic                           mon_en;
  logic [NUM_THR-1:0][TEMP_W-1:0] thr;
  logic                           n2h_set;
  logic [DATA_W-1:0]              int_en;
  logic                           clr_we;
  logic [DATA_W-1:0]              clr_vec;
  logic [DATA_W-1:0]              set_vec;
  logic [DATA_W-1:0]              status;
  logic [DATA_W-1:0]              rd_mux;

  thmon_regs #(.TEMP_W(TEMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .mon_en  (mon_en),
    .thr     (thr),
    .n2h_set (n2h_set),
    .int_en  (int_en),
    .clr_we  (clr_we),
    .clr_vec (clr_vec)
  );

  thmon_compare #(.TEMP_W(TEMP_W), .DATA_W(DATA_W)) u_cmp (
    .smp_valid (smp_valid),
    .smp_code  (smp_code),
    .mon_en    (mon_en),
    .thr       (thr),
    .n2h_set   (n2h_set),
    .set_vec   (set_vec)
  );

  thmon_status #(.DATA_W(DATA_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_we  (clr_we),
    .clr_vec (clr_vec),
    .int_en  (int_en),
    .status  (status),
    .irq     (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADR_CTRL))  rd_mux = DATA_W'(mon_en);
    if (reg_addr == ADDR_W'(ADR_INTEN)) rd_mux = int_en;
    if (reg_addr == ADDR_W'(ADR_STAT))  rd_mux = status;
    for (int i = 0; i < NUM_THR; i++) begin
      if (reg_addr == ADDR_W'(ADR_THR0 + i)) rd_mux = DATA_W'(thr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R10: no accepted sample and no clear means status holds
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!(smp_valid && mon_en) && !clr_we) |=> $stable(status));

  // R5: hot bit never rises without its normal-to-hot partner
  p_hot_pair_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(status[ST_HOT]) |-> status[ST_N2H]);

  // R9: with the mask empty for two cycles the interrupt is low
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (rst)
    ((int_en == '0) && ($past(int_en) == '0)) |-> !irq);
endmodule

// File: tb/test_thermal_irq_monitor.sv
module test_thermal_irq_monitor;
  localparam int TW = 12;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CTRL = 3'd0, A_HOT = 3'd1, A_N2H = 3'd2, A_COLD = 3'd3,
                            A_LOFS = 3'd4, A_HOFS = 3'd5, A_EN = 3'd6, A_STAT = 3'd7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          smp_valid = 1'b0;
  logic [TW-1:0] smp_code = '0;
  logic          irq;

  thermal_irq_monitor #(.TEMP_W(TW), .DATA_W(DW), .ADDR_W(AW)) i_thermal_irq_monitor (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .smp_valid(smp_valid), .smp_code(smp_code), .irq(irq)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit            is_irq;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;

  item_t q[$];
  logic  pend = 1'b0;
  logic  pend_q = 1'b0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) pend_q <= pend;

  // monitor: pops one expectation per completed read slot
  always @(negedge clk) begin
    if (pend_q && q.size() > 0) begin
      item_t it;
      logic [DW-1:0] got;
      it  = q.pop_front();
      got = it.is_irq ? DW'(irq) : reg_rdata;
      n_cmp++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic expect_reg(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    pend = 1'b1;
    @(negedge clk);
    pend = 1'b0;
  endtask

  task automatic expect_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = DW'(e); it.tag = tag;
    q.push_back(it);
    pend = 1'b1;
    @(negedge clk);
    pend = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic smp(input logic [TW-1:0] c);
    @(negedge clk);
    smp_valid = 1'b1; smp_code = c;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic clr_and_smp(input logic [DW-1:0] w, input logic [TW-1:0] c);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_STAT; reg_wdata = w;
    smp_valid = 1'b1; smp_code = c;
    @(negedge clk);
    reg_we = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic clr_all();
    wr(A_STAT, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    expect_reg(A_STAT, 32'h0, "R11 status");
    expect_reg(A_EN,   32'h0, "R11 enable");
    expect_reg(A_CTRL, 32'h0, "R11 control");
    expect_reg(A_COLD, 32'h0, "R11 cold");
    expect_irq(1'b0, "R11 irq");

    // R1: only 12 bits stored
    wr(A_HOT, 32'hFFFF_FABC);
    expect_reg(A_HOT, 32'h0000_0ABC, "R1 hot width");

    wr(A_COLD, 32'h100);
    wr(A_LOFS, 32'h200);
    wr(A_HOFS, 32'h800);
    wr(A_HOT,  32'hA00);

    // R10: disabled monitor ignores samples
    smp(12'h000);
    expect_reg(A_STAT, 32'h0, "R10 disabled");
    wr(A_CTRL, 32'h1);
    expect_reg(A_CTRL, 32'h1, "R1 control");
    smp(12'h500);
    expect_reg(A_STAT, 32'h0, "R10 quiet sample");

    // R2
    smp(12'h800);
    expect_reg(A_STAT, 32'h0, "R2 at limit");
    smp(12'h801);
    expect_reg(A_STAT, 32'h4, "R2 above");
    clr_all();

    // R3
    smp(12'h200);
    expect_reg(A_STAT, 32'h0, "R3 at limit");
    smp(12'h1FF);
    expect_reg(A_STAT, 32'h8, "R3 below");
    clr_all();

    // R4
    smp(12'h0FF);
    expect_reg(A_STAT, 32'hA, "R4 below cold");
    clr_all();
    smp(12'h100);
    expect_reg(A_STAT, 32'h8, "R4 at cold");
    clr_all();

    // R6: normal-to-hot never written, cold 0x100 stands in
    wr(A_HOT, 32'h050);
    expect_reg(A_N2H, 32'h0, "R6 n2h unwritten");
    smp(12'h100);
    expect_reg(A_STAT, 32'h8, "R6 at fallback");
    smp(12'h101);
    expect_reg(A_STAT, 32'h19, "R6 above fallback");
    clr_all();

    // R5: larger of hot and normal-to-hot
    wr(A_HOT, 32'hA00);
    wr(A_N2H, 32'hC00);
    smp(12'hC00);
    expect_reg(A_STAT, 32'h4, "R5 n2h limit");
    smp(12'hC01);
    expect_reg(A_STAT, 32'h15, "R5 above n2h");
    clr_all();
    wr(A_N2H, 32'h300);
    smp(12'hA00);
    expect_reg(A_STAT, 32'h4, "R5 hot limit");
    clr_all();
    smp(12'hA01);
    expect_reg(A_STAT, 32'h15, "R5 above hot");

    // R7: sticky and selective clear
    smp(12'h500);
    expect_reg(A_STAT, 32'h15, "R7 sticky");
    wr(A_STAT, 32'h4);
    expect_reg(A_STAT, 32'h11, "R7 partial clear");

    // R9: masking
    wr(A_EN, 32'h10);
    expect_irq(1'b1, "R9 enabled bit");
    wr(A_EN, 32'h8);
    expect_reg(A_EN, 32'h8, "R9 enable readback");
    expect_irq(1'b0, "R9 masked");
    wr(A_EN, 32'h1);
    expect_irq(1'b1, "R9 bit0");
    wr(A_STAT, 32'h11);
    expect_irq(1'b0, "R9 cleared");

    // R12: writes cannot set status
    wr(A_STAT, 32'hFFFF_FFFF);
    expect_reg(A_STAT, 32'h0, "R12 no set by write");

    // R8: set wins over clear
    wr(A_EN, 32'h4);
    smp(12'h801);
    expect_reg(A_STAT, 32'h4, "R8 pre-set");
    expect_irq(1'b1, "R9 offset irq");
    clr_and_smp(32'h4, 12'h801);
    expect_reg(A_STAT, 32'h4, "R8 set wins");
    clr_and_smp(32'h4, 12'h500);
    expect_reg(A_STAT, 32'h0, "R7 clear with quiet sample");
    expect_irq(1'b0, "R9 low after clear");

    // R10: switched off again
    wr(A_CTRL, 32'h0);
    smp(12'hFFF);
    expect_reg(A_STAT, 32'h0, "R10 off again");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule